// File: doc/BRIEF.md
# Nibble-Step CRC-32 Bus Slave

This block computes an Ethernet-style CRC-32 four bits at a time and is reached through a Wishbone classic slave port with an 8-bit data bus. A master writes a nibble on the low four data lines of the data register, and each accepted write folds those four bits into the running checksum. The checksum uses the reflected form of generator 0x04C11DB7 (shift constant 0xEDB88320), processes each nibble least significant bit first, and starts from an all-ones state. The value visible to the master is the bitwise complement of that state. A byte stream is therefore fed low nibble first.

A control register re-presets the checksum and picks which half of the 32-bit result the two result offsets show. The slave does no decoding beyond its own two address bits: an outside bus controller selects it by driving the strobe. Each strobe is answered by a registered acknowledge one cycle long, so a master that keeps the strobe high gets one transfer every second cycle.

Top module: `crc_nib_wb`

## Requirements
- R1: While and after a synchronous reset, ack_o is low and the result reads as 0x00000000 (complement of the all-ones preset); the half select returns to 0.
- R2: A transfer is accepted only when cyc_i and stb_i are both high; ack_o rises in the cycle after acceptance, and a strobe with cyc_i low gives no acknowledge and does not change the checksum.
- R3: ack_o is high for exactly one cycle per accepted transfer; a strobe held high continuously is accepted every second cycle, and each acceptance updates the checksum exactly once.
- R4: A write at address 0 folds dat_i[3:0] into the state, bit 0 first, using reflected polynomial shift constant 0xEDB88320; feeding the ASCII bytes "123456789" low nibble first yields result 0xCBF43926.
- R5: dat_i[7:4] has no effect on a write at address 0.
- R6: A write at address 1 with bit 0 set presets the state to all ones (result 0x00000000); bit 0 clear leaves the checksum unchanged; bit 1 of the same write is stored as the half select.
- R7: A read at address 2 returns result byte 0 (bits 7:0) when the half select is 0 and byte 2 (bits 23:16) when it is 1; a read at address 3 returns byte 1 (bits 15:8) or byte 3 (bits 31:24) correspondingly.
- R8: A read at address 0 returns 0x00 and a read at address 1 returns the half select in bit 1 with all other bits 0; writes at addresses 2 and 3 change nothing.
- R9: Read transfers never change the checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Strobe selecting this slave |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | 2 | Register offset |
| dat_i | input | 8 | Write data; only bits 3:0 feed the checksum |
| dat_o | output | 8 | Read data, valid while ack_o is high |
| ack_o | output | 1 | Registered one-cycle acknowledge |

## Verification
A corrupted checksum state stays hidden until the master reads a result byte, so the bench reads all four bytes after each scenario; one wrong nibble step differs from the expected value in the very next read. A handshake fault appears immediately on ack_o: a missing, doubled or stretched acknowledge shows in the cycle after the strobe, and a doubled acceptance under a held strobe shows later as a checksum that has folded the nibble too many times. A wrong half select or byte lane shows as a byte of the right value in the wrong read.

// File: rtl/crc_nib_pkg.sv
package crc_nib_pkg;
    localparam int CRC_W  = 32;
    localparam int NIB_W  = 4;
    localparam int DAT_W  = 8;
    localparam int ADR_W  = 2;
    localparam int BYTES  = CRC_W / DAT_W;
    localparam logic [CRC_W-1:0] CRC_PRESET = '1;
    localparam logic [CRC_W-1:0] CRC_RPOLY  = 32'hEDB88320;

    typedef enum logic [ADR_W-1:0] {
        OFS_DATA = 2'd0,
        OFS_CTRL = 2'd1,
        OFS_RLO  = 2'd2,
        OFS_RHI  = 2'd3
    } ofs_e;

    typedef struct packed {
        logic              upd;
        logic              preset;
        logic [NIB_W-1:0]  nib;
    } crc_cmd_t;

    function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] s,
                                                  input logic [NIB_W-1:0] n);
        logic [CRC_W-1:0] r;
        r = s;
        for (int i = 0; i < NIB_W; i++) begin
            if (r[0] ^ n[i]) r = (r >> 1) ^ CRC_RPOLY;
            else             r = r >> 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/crc_nib_core.sv
module crc_nib_core
    import crc_nib_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  crc_cmd_t         cmd,
    output logic [CRC_W-1:0] result
);
    logic [CRC_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst || cmd.preset) state_q <= CRC_PRESET;
        else if (cmd.upd)      state_q <= crc_fold(state_q, cmd.nib);
    end

    assign result = ~state_q;

    // R6: preset leaves the all-ones state
    a_r6_preset_ones: assert property (@(posedge clk) disable iff (rst)
        cmd.preset |=> (result == '0));

    // R9: without a command the state holds
    a_r9_state_hold: assert property (@(posedge clk) disable iff (rst)
        (!cmd.upd && !cmd.preset) |=> $stable(result));
endmodule

// File: rtl/crc_nib_wb_if.sv
module crc_nib_wb_if
    import crc_nib_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc,
    input  logic             stb,
    input  logic             we,
    input  logic [ADR_W-1:0] adr,
    input  logic [DAT_W-1:0] wdat,
    input  logic [CRC_W-1:0] result,
    output crc_cmd_t         cmd,
    output logic [DAT_W-1:0] rdat,
    output logic             ack
);
    logic             ack_q;
    logic             half_q;
    logic [DAT_W-1:0] rdat_q;
    logic             accept;
    logic [DAT_W-1:0] rd_mux;
    logic [DAT_W-1:0] res_byte [BYTES];
    wire              unused_hi = ^wdat[DAT_W-1:NIB_W];

    assign accept = cyc && stb && !ack_q;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign res_byte[b] = result[b*DAT_W +: DAT_W];
    end

    always_comb begin
        rd_mux = '0;
        case (ofs_e'(adr))
            OFS_CTRL: rd_mux[1] = half_q;
            OFS_RLO:  rd_mux = half_q ? res_byte[2] : res_byte[0];
            OFS_RHI:  rd_mux = half_q ? res_byte[3] : res_byte[1];
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q  <= 1'b0;
            half_q <= 1'b0;
            rdat_q <= '0;
        end else begin
            ack_q <= accept;
            if (accept && we && ofs_e'(adr) == OFS_CTRL) half_q <= wdat[1];
            if (accept && !we) rdat_q <= rd_mux;
        end
    end

    assign cmd.upd    = accept && we && ofs_e'(adr) == OFS_DATA;
    assign cmd.preset = accept && we && ofs_e'(adr) == OFS_CTRL && wdat[0];
    assign cmd.nib    = wdat[NIB_W-1:0];
    assign rdat       = rdat_q;
    assign ack        = ack_q;

    // R3: acknowledge never lasts two cycles
    a_r3_ack_single: assert property (@(posedge clk) disable iff (rst)
        ack_q |=> !ack_q);

    // R2: acknowledge only follows a qualified request
    a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_q) |-> $past(cyc && stb));

    // R2: no cycle, no acknowledge
    a_r2_no_cyc_no_ack: assert property (@(posedge clk) disable iff (rst)
        !cyc |=> !ack_q);

    // R1: reset drops the acknowledge
    a_r1_reset_ack: assert property (@(posedge clk)
        rst |=> !ack_q);
endmodule

// File: rtl/crc_nib_wb.sv
module crc_nib_wb
    import crc_nib_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cyc_i,
    input  logic             stb_i,
    input  logic             we_i,
    input  logic [ADR_W-1:0] adr_i,
    input  logic [DAT_W-1:0] dat_i,
    output logic [DAT_W-1:0] dat_o,
    output logic             ack_o
);
    crc_cmd_t         cmd;
    logic [CRC_W-1:0] result;

    crc_nib_wb_if u_if (
        .clk(clk_i), .rst(rst_i), .cyc(cyc_i), .stb(stb_i), .we(we_i),
        .adr(adr_i), .wdat(dat_i), .result(result), .cmd(cmd),
        .rdat(dat_o), .ack(ack_o)
    );

    crc_nib_core u_core (
        .clk(clk_i), .rst(rst_i), .cmd(cmd), .result(result)
    );
endmodule

// File: tb/tb_crc_nib_wb.sv
module tb_crc_nib_wb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [1:0] adr = '0;
    logic [7:0] dat = '0;
    logic [7:0] dat_o;
    logic       ack;
    int         n_run = 0, n_fail = 0;
    logic [31:0] model;

    always #2.5 clk = ~clk;

    crc_nib_wb dut (.clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
                    .adr_i(adr), .dat_i(dat), .dat_o(dat_o), .ack_o(ack));

    function automatic logic [31:0] step(input logic [31:0] s, input logic [3:0] n);
        logic [31:0] r = s;
        for (int i = 0; i < 4; i++)
            r = (r[0] ^ n[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [1:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output logic got);
        @(negedge clk);
        cyc = 1; stb = 1; we = w; adr = a; dat = d;
        @(posedge clk); #1;
        got = ack; rd = dat_o;
        @(negedge clk);
        cyc = 0; stb = 0; we = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        logic [7:0] rd; logic g;
        xfer(1'b1, a, d, rd, g);
        check("R2 write ack", {31'b0, g}, 32'd1);
    endtask

    task automatic rdr(input logic [1:0] a, output logic [7:0] rd);
        logic g;
        xfer(1'b0, a, 8'h00, rd, g);
        check("R2 read ack", {31'b0, g}, 32'd1);
    endtask

    task automatic read_crc(output logic [31:0] v);
        logic [7:0] b0, b1, b2, b3;
        wr(2'd1, 8'h00); rdr(2'd2, b0); rdr(2'd3, b1);
        wr(2'd1, 8'h02); rdr(2'd2, b2); rdr(2'd3, b3);
        wr(2'd1, 8'h00);
        v = {b3, b2, b1, b0};
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 ack in reset", {31'b0, ack}, 32'd0);
        @(negedge clk); rst = 0;
        read_crc(v);
        check("R1 reset result", v, 32'h0);
        model = 32'hFFFFFFFF;
    endtask

    task automatic t_vector;
        string s = "123456789";
        logic [31:0] v;
        wr(2'd1, 8'h01); model = 32'hFFFFFFFF;
        for (int i = 0; i < 9; i++) begin
            wr(2'd0, {4'h0, s[i][3:0]}); model = step(model, s[i][3:0]);
            wr(2'd0, {4'h0, s[i][7:4]}); model = step(model, s[i][7:4]);
        end
        read_crc(v);
        check("R4 check vector", v, 32'hCBF43926);
        check("R9 reads kept state", v, ~model);
    endtask

    task automatic t_upper_ignored;
        logic [31:0] v;
        wr(2'd0, 8'hF5); model = step(model, 4'h5);
        wr(2'd0, 8'hA3); model = step(model, 4'h3);
        read_crc(v);
        check("R5 upper bits ignored", v, ~model);
    endtask

    task automatic t_ctrl;
        logic [31:0] v; logic [7:0] rd;
        wr(2'd1, 8'h00);
        read_crc(v);
        check("R6 ctrl bit0 clear keeps", v, ~model);
        wr(2'd1, 8'h03); model = 32'hFFFFFFFF;
        rdr(2'd1, rd);
        check("R8 ctrl readback half", {24'b0, rd}, 32'h02);
        rdr(2'd2, rd);
        check("R6 preset result byte2", {24'b0, rd}, 32'h0);
        read_crc(v);
        check("R6 preset result", v, 32'h0);
    endtask

    task automatic t_lanes;
        logic [7:0] rd; logic [31:0] v;
        for (int i = 0; i < 6; i++) begin
            wr(2'd0, {4'h0, 4'(i * 3 + 1)}); model = step(model, 4'(i * 3 + 1));
        end
        v = ~model;
        wr(2'd1, 8'h00);
        rdr(2'd2, rd); check("R7 byte0", {24'b0, rd}, {24'b0, v[7:0]});
        rdr(2'd3, rd); check("R7 byte1", {24'b0, rd}, {24'b0, v[15:8]});
        wr(2'd1, 8'h02);
        rdr(2'd2, rd); check("R7 byte2", {24'b0, rd}, {24'b0, v[23:16]});
        rdr(2'd3, rd); check("R7 byte3", {24'b0, rd}, {24'b0, v[31:24]});
        rdr(2'd0, rd); check("R8 offset0 reads zero", {24'b0, rd}, 32'h0);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h01); wr(2'd3, 8'h0F);
        read_crc(v);
        check("R8 writes at 2,3 ignored", v, ~model);
    endtask

    task automatic t_no_cyc;
        int acks = 0; logic [31:0] v;
        @(negedge clk); cyc = 0; stb = 1; we = 1; adr = 2'd0; dat = 8'h07;
        repeat (4) begin @(posedge clk); #1; if (ack) acks++; end
        @(negedge clk); stb = 0; we = 0;
        check("R2 no ack without cyc", acks, 0);
        read_crc(v);
        check("R2 no update without cyc", v, ~model);
    endtask

    task automatic t_held;
        int acks = 0; logic [31:0] v; logic prev = 0; int dbl = 0;
        @(negedge clk); cyc = 1; stb = 1; we = 1; adr = 2'd0; dat = 8'h09;
        repeat (4) begin
            @(posedge clk); #1;
            if (ack) acks++;
            if (ack && prev) dbl++;
            prev = ack;
        end
        @(negedge clk); cyc = 0; stb = 0; we = 0;
        model = step(step(model, 4'h9), 4'h9);
        check("R3 two acks in four cycles", acks, 2);
        check("R3 no stretched ack", dbl, 0);
        @(posedge clk); #1;
        check("R3 ack low after release", {31'b0, ack}, 32'd0);
        read_crc(v);
        check("R3 one update per ack", v, ~model);
    endtask

    task automatic t_reset_mid;
        logic [31:0] v; int acks = 0;
        wr(2'd0, 8'h0C);
        @(negedge clk); rst = 1; cyc = 1; stb = 1; we = 1; adr = 2'd0; dat = 8'h05;
        repeat (2) begin @(posedge clk); #1; if (ack) acks++; end
        @(negedge clk); rst = 0; cyc = 0; stb = 0; we = 0;
        check("R1 no ack during reset", acks, 0);
        read_crc(v);
        check("R1 reset re-presets", v, 32'h0);
        model = 32'hFFFFFFFF;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset;
        t_vector;
        t_upper_ignored;
        t_ctrl;
        t_lanes;
        t_no_cyc;
        t_held;
        t_reset_mid;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule